// File: doc/BRIEF.md
# Set-walking data cache flush sequencer

This block empties a set-associative data cache without software issuing each flush one at a time. After a start pulse it produces a stream of flush-by-entry operations from four values latched at start: a base address, the number of address steps, how many times each address is issued, and the step between addresses. Every operation removes at most one line. The cache side chooses that line as the lowest-numbered valid way of the set that the address selects. A dirty line leaves through a copy-out port as it is dropped.

Because one operation clears only one way, issuing the same address several times in a row is not the intended way to empty a set. The intended way is to walk the whole index range once per way: for the default geometry of 384 sets and 4 ways, this is a count of 0x600 (four passes of 0x180) with a stride of 0x80 and one issue per address. The default sequence values are base 0x0, count 0x180, repeat 1 and stride 0x80. Addresses are physical, and no hashing is applied to them. The top module also holds a small cache tag model so that it can be used on its own. That model has a line install port that preloads lines.

Top module: `cache_flush_walker`

## Requirements
- R1: After reset, busy, done, op_done, op_hit and copy_valid are all 0 and the cache model holds no valid line.
- R2: A start pulse taken while idle latches base, count, repeat and stride and raises busy on the next edge. Operations are then issued to base, each address repeat times, and the address advances by stride after each group, for count groups (count × repeat operations in all). op_addr reports the address of each completed operation.
- R3: A repeat value of 0 is treated as 1.
- R4: done is high for exactly one cycle, in the cycle after the last op_done, and busy is low in that cycle. A count of 0 gives done in the cycle after start, with no operation.
- R5: An operation at address A works on set (A >> 7) mod SETS. It invalidates the lowest-numbered valid way of that set and reports op_hit=1 and op_way. When the set is empty, it reports op_hit=0 and changes nothing.
- R6: When the invalidated line is dirty, copy_valid pulses together with op_done, and copy_addr carries the line's address with the low 7 bits zero. A clean line and a miss give no copy-out.
- R7: At most one operation is outstanding. Each operation sees the result of the one before it, and completions are spaced exactly 2 cycles apart.
- R8: A start pulse while busy is ignored, together with any cfg values presented with it. The running sequence continues unchanged.
- R9: An install (fill_valid) places the line in the lowest-numbered free way of its set. When the set is full, the install is dropped.
- R10: A walk of count 4 × SETS with stride 0x80 and repeat 1 from base 0 removes every line. A single pass of count 0x180 removes only one line per set.
- R11: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| cfg_base | input | ADDR_W | First flush address |
| cfg_count | input | CNT_W | Number of address steps |
| cfg_loop | input | LOOP_W | Issues per address (0 acts as 1) |
| cfg_stride | input | ADDR_W | Address increment per step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fill_valid | input | 1 | Install a line into the cache model |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_dirty | input | 1 | Installed line is dirty |
| op_done | output | 1 | A flush operation completed |
| op_addr | output | ADDR_W | Address of the completed operation |
| op_hit | output | 1 | The operation invalidated a line |
| op_way | output | WAY_W | Way that was invalidated |
| copy_valid | output | 1 | Dirty line copied out |
| copy_addr | output | ADDR_W | Line address of the copied-out data |

## Verification
On every cycle, the embedded assertions check the handshake between the sequencer and the cache model: a completion only follows a request, and a request holds its address until it is acknowledged. They also check that done coincides with busy falling, that the repeat index stays below its limit, and that a copy-out never appears without an invalidation. The bench scenarios are what show the exact address order, which way each operation picks, the dropped install in a full set, the cycle of done, and that four index passes empty a loaded cache while one pass does not.

// File: rtl/flush_pkg.sv
// Package: shared constants for the set-walking flush sequencer.
// Holds the default sequence values and the sequencer state encoding.
package flush_pkg;
    localparam int unsigned DEF_BASE   = 32'h0;
    localparam int unsigned DEF_COUNT  = 32'h180;
    localparam int unsigned DEF_LOOP   = 32'd1;
    localparam int unsigned DEF_STRIDE = 32'h80;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/flush_way_pick.sv
// Module: flush_way_pick
// Finds the lowest-numbered asserted bit in a per-way candidate vector.
// Assumes WAYS >= 2. Purely combinational.
module flush_way_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  cand,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    // Scan from the top so the lowest candidate is written last.
    always_comb begin
        found = |cand;
        way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (cand[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/flush_seq.sv
// Module: flush_seq
// Walks the flush address stream: base, each address repeated, then +stride.
// Assumes the cache side answers a held request with a one-cycle ack.
module flush_seq
    import flush_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int LOOP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [LOOP_W-1:0] cfg_loop,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic              ack,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done
);
    seq_state_t        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  iter_q;
    logic [LOOP_W-1:0] loop_q;
    logic [LOOP_W-1:0] rep_q;
    logic              done_q;

    // Sequencer state, counters and address walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            addr_q   <= '0;
            stride_q <= '0;
            cnt_q    <= '0;
            iter_q   <= '0;
            loop_q   <= '0;
            rep_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == SQ_IDLE) begin
                if (start) begin
                    addr_q   <= cfg_base;
                    stride_q <= cfg_stride;
                    cnt_q    <= cfg_count;
                    loop_q   <= (cfg_loop == '0) ? LOOP_W'(1) : cfg_loop;
                    iter_q   <= '0;
                    rep_q    <= '0;
                    if (cfg_count == '0) done_q  <= 1'b1;
                    else                 state_q <= SQ_RUN;
                end
            end else if (ack) begin
                if (rep_q + LOOP_W'(1) < loop_q) begin
                    rep_q <= rep_q + LOOP_W'(1);
                end else begin
                    rep_q  <= '0;
                    addr_q <= addr_q + stride_q;
                    iter_q <= iter_q + CNT_W'(1);
                    if (iter_q + CNT_W'(1) == cnt_q) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            end
        end
    end

    // Request is held for the whole run; the cache gates it with its ack.
    always_comb begin
        busy     = (state_q == SQ_RUN);
        req      = busy;
        req_addr = addr_q;
        done     = done_q;
    end

    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r4_fall_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cnt_q) && $stable(stride_q) && $stable(loop_q)));
    a_r2_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rep_q < loop_q));
endmodule

// File: rtl/flush_cache_model.sv
// Module: flush_cache_model
// Tag-only set-associative cache model answering flush-by-entry requests.
// Assumes physical addresses, set = line number mod SETS, one request in flight.
module flush_cache_model #(
    parameter int ADDR_W = 20,
    parameter int OFF_W  = 7,
    parameter int SETS   = 384,
    parameter int WAYS   = 4,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    output logic              ack,
    output logic [ADDR_W-1:0] op_addr,
    output logic              op_hit,
    output logic [WAY_W-1:0]  op_way,
    output logic              copy_valid,
    output logic [ADDR_W-1:0] copy_addr
);
    logic [LINE_W-1:0] req_line, fill_line;
    logic [IDX_W-1:0]  req_idx, fill_idx;
    logic [WAYS-1:0]   req_valid, req_dirty, fill_used;
    logic [LINE_W-1:0] req_tags [WAYS];
    logic              take, do_fill;
    logic              hit_found, free_found;
    logic [WAY_W-1:0]  hit_way, free_way;

    // Set selection for the flush request and the install.
    always_comb begin
        req_line  = req_addr[ADDR_W-1:OFF_W];
        fill_line = fill_addr[ADDR_W-1:OFF_W];
        req_idx   = IDX_W'(req_line % LINE_W'(SETS));
        fill_idx  = IDX_W'(fill_line % LINE_W'(SETS));
        take      = req && !ack;
        do_fill   = fill_valid && !take && free_found;
    end

    flush_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) i_pick_hit (
        .cand(req_valid), .found(hit_found), .way(hit_way));
    flush_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) i_pick_free (
        .cand(~fill_used), .found(free_found), .way(free_way));

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic              v_mem [SETS];
        logic              d_mem [SETS];
        logic [LINE_W-1:0] l_mem [SETS];

        assign req_valid[w] = v_mem[req_idx];
        assign req_dirty[w] = d_mem[req_idx];
        assign req_tags[w]  = l_mem[req_idx];
        assign fill_used[w] = v_mem[fill_idx];

        // Per-way state: invalidate on flush hit, install on free-way fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) v_mem[s] <= 1'b0;
            end else if (take && hit_found && hit_way == WAY_W'(w)) begin
                v_mem[req_idx] <= 1'b0;
            end else if (do_fill && free_way == WAY_W'(w)) begin
                v_mem[fill_idx] <= 1'b1;
                d_mem[fill_idx] <= fill_dirty;
                l_mem[fill_idx] <= fill_line;
            end
        end
    end

    // Registered response: ack, outcome and copy-out of a dirty victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack        <= 1'b0;
            op_addr    <= '0;
            op_hit     <= 1'b0;
            op_way     <= '0;
            copy_valid <= 1'b0;
            copy_addr  <= '0;
        end else begin
            ack        <= take;
            op_hit     <= take && hit_found;
            copy_valid <= take && hit_found && req_dirty[hit_way];
            if (take) begin
                op_addr   <= req_addr;
                op_way    <= hit_way;
                copy_addr <= {req_tags[hit_way], {OFF_W{1'b0}}};
            end
        end
    end

    a_r6_copy_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> (op_hit && ack));
    a_r5_hit_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        op_hit |-> ack);
endmodule

// File: rtl/cache_flush_walker.sv
// Module: cache_flush_walker (top)
// Flush sequencer bound to a tag-only cache model, with an install port.
// Assumes installs are presented only while no flush sequence is running.
module cache_flush_walker #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int LOOP_W = 4,
    parameter int OFF_W  = 7,
    parameter int SETS   = 384,
    parameter int WAYS   = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [LOOP_W-1:0] cfg_loop,
    input  logic [ADDR_W-1:0] cfg_stride,
    output logic              busy,
    output logic              done,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    output logic              op_done,
    output logic [ADDR_W-1:0] op_addr,
    output logic              op_hit,
    output logic [WAY_W-1:0]  op_way,
    output logic              copy_valid,
    output logic [ADDR_W-1:0] copy_addr
);
    logic              req, ack;
    logic [ADDR_W-1:0] req_addr;

    flush_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_base(cfg_base), .cfg_count(cfg_count),
        .cfg_loop(cfg_loop), .cfg_stride(cfg_stride),
        .ack(ack), .req(req), .req_addr(req_addr),
        .busy(busy), .done(done));

    flush_cache_model #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) i_cache (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
        .ack(ack), .op_addr(op_addr), .op_hit(op_hit), .op_way(op_way),
        .copy_valid(copy_valid), .copy_addr(copy_addr));

    // Completion pulse is the cache acknowledge.
    assign op_done = ack;

    a_r7_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(req_addr)));
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: tb/test_cache_flush_walker.sv
module test_cache_flush_walker;
    localparam int ADDR_W = 20;
    localparam int CNT_W  = 16;
    localparam int LOOP_W = 4;
    localparam int SETS   = 384;
    localparam int WAYS   = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              hit;
        logic [1:0]        way;
        logic              cp;
        logic [ADDR_W-1:0] caddr;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0, cfg_stride = '0, fill_addr = '0;
    logic [CNT_W-1:0]  cfg_count = '0;
    logic [LOOP_W-1:0] cfg_loop = '0;
    logic fill_valid = 1'b0, fill_dirty = 1'b0;
    logic busy, done, op_done, op_hit, copy_valid;
    logic [ADDR_W-1:0] op_addr, copy_addr;
    logic [1:0] op_way;

    int checks = 0, fails = 0, cyc = 0;
    int last_op = -1, start_cyc = 0, hit_cnt = 0;
    bit done_seen = 0, prev_done = 0, expect_ops = 0;
    exp_t q[$];
    bit rv [SETS][WAYS];
    bit rd [SETS][WAYS];
    logic [ADDR_W-8:0] rl [SETS][WAYS];

    cache_flush_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W),
                         .SETS(SETS), .WAYS(WAYS)) i_cache_flush_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_count(cfg_count), .cfg_loop(cfg_loop), .cfg_stride(cfg_stride),
        .busy(busy), .done(done), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_dirty(fill_dirty), .op_done(op_done), .op_addr(op_addr),
        .op_hit(op_hit), .op_way(op_way), .copy_valid(copy_valid),
        .copy_addr(copy_addr));

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    function automatic int set_of(input logic [ADDR_W-1:0] a);
        return int'(a >> 7) % SETS;
    endfunction

    // Monitor: pops expected operations and checks completion timing.
    always @(negedge clk) begin
        if (rst_n) begin
            if (op_done) begin
                if (q.size() == 0) begin
                    chk(0, "R2 unexpected operation", op_addr, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(op_addr == e.addr, "R2 op address", op_addr, e.addr);
                    chk(op_hit == e.hit, "R5 hit", op_hit, e.hit);
                    if (e.hit) chk(op_way == e.way, "R5 way", op_way, e.way);
                    chk(copy_valid == e.cp, "R6 copy pulse", copy_valid, e.cp);
                    if (e.cp) chk(copy_addr == e.caddr, "R6 copy address", copy_addr, e.caddr);
                end
                if (last_op >= 0) chk(cyc - last_op == 2, "R7 spacing", cyc - last_op, 2);
                last_op = cyc;
                if (op_hit) hit_cnt++;
            end else if (copy_valid) begin
                chk(0, "R6 copy without operation", 1, 0);
            end
            if (done) begin
                chk(!prev_done, "R4 single-cycle done", prev_done, 0);
                chk(!busy, "R4 busy low at done", busy, 0);
                if (expect_ops) chk(cyc - last_op == 1, "R4 done timing", cyc - last_op, 1);
                else            chk(cyc == start_cyc + 1, "R4 zero count done", cyc, start_cyc + 1);
                done_seen = 1;
            end
            prev_done = done;
        end
    end

    task automatic do_fill(input logic [ADDR_W-1:0] a, input bit d);
        int s;
        int w;
        s = set_of(a);
        w = -1;
        for (int k = WAYS - 1; k >= 0; k--) if (!rv[s][k]) w = k;
        if (w >= 0) begin
            rv[s][w] = 1;
            rd[s][w] = d;
            rl[s][w] = a[ADDR_W-1:7];
        end
        @(negedge clk); #1;
        fill_valid = 1'b1; fill_addr = a; fill_dirty = d;
        @(negedge clk); #1;
        fill_valid = 1'b0;
    endtask

    // Driver: computes expected operations from the requirements, then starts.
    task automatic run_flush(input logic [ADDR_W-1:0] base, input int count,
                             input int loop, input logic [ADDR_W-1:0] stride,
                             input bit poke);
        logic [ADDR_W-1:0] a;
        int eff;
        a = base;
        eff = (loop == 0) ? 1 : loop;
        for (int i = 0; i < count; i++) begin
            for (int r = 0; r < eff; r++) begin
                exp_t e;
                int s;
                s = set_of(a);
                e = '0;
                e.addr = a;
                for (int k = WAYS - 1; k >= 0; k--) if (rv[s][k]) begin e.hit = 1; e.way = 2'(k); end
                if (e.hit) begin
                    e.cp = rd[s][e.way];
                    e.caddr = {rl[s][e.way], 7'b0};
                    rv[s][e.way] = 0;
                end
                q.push_back(e);
            end
            a = a + stride;
        end
        done_seen = 0; last_op = -1; hit_cnt = 0; expect_ops = (count != 0);
        @(negedge clk); #1;
        cfg_base = base; cfg_count = CNT_W'(count); cfg_loop = LOOP_W'(loop);
        cfg_stride = stride; start = 1'b1; start_cyc = cyc;
        @(negedge clk); #1;
        start = 1'b0;
        if (count != 0) chk(busy, "R2 busy after start", busy, 1);
        if (poke) begin
            @(negedge clk); #1;
            cfg_base = 20'h12340; cfg_count = 16'd1; cfg_loop = 4'd3; start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        #1;
        chk(q.size() == 0, "R2 all operations issued", q.size(), 0);
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !op_done, "R8 idle after run", {busy, done, op_done}, 0);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        forever begin
            @(posedge clk);
            if (cyc >= 150000) begin
                fails++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] lf;
        for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin rv[s][w] = 0; rd[s][w] = 0; rl[s][w] = '0; end
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        chk(!busy && !done, "R1 busy/done at reset", {busy, done}, 0);
        chk(!op_done && !op_hit && !copy_valid, "R1 outputs at reset", {op_done, op_hit, copy_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);

        // R2/R5: empty cache, repeat 2, three steps
        run_flush(20'h100, 3, 2, 20'h80, 0);
        // R9: five installs into set 0, fifth dropped
        do_fill(20'h00000, 0);
        do_fill(20'(SETS * 128), 1);
        do_fill(20'(2 * SETS * 128), 0);
        do_fill(20'(3 * SETS * 128), 1);
        do_fill(20'(4 * SETS * 128), 1);
        // R7/R5/R6: repeated issues to one set each see prior state
        run_flush(20'h0, 1, 2, 20'h80, 0);
        // R3: repeat 0 acts as 1
        run_flush(20'h0, 2, 0, 20'h0, 0);
        // R9: the set is empty now although five installs were made
        run_flush(20'h0, 1, 1, 20'h80, 0);
        // R4: count 0
        run_flush(20'h0, 0, 1, 20'h80, 0);
        // R8: start during a run is ignored
        do_fill(20'h00280, 1);
        run_flush(20'h00200, 6, 1, 20'h80, 1);
        // R11: address wrap
        do_fill(20'h00000, 1);
        run_flush(20'hFFF80, 2, 1, 20'h80, 0);
        // R10: one pass leaves extra lines, four passes empty everything
        do_fill(20'h00280, 1);
        do_fill(20'(20'h00280 + SETS * 128), 0);
        do_fill(20'(20'h00280 + 2 * SETS * 128), 1);
        run_flush(20'h0, 16'h180, 1, 20'h80, 0);
        chk(hit_cnt == 1, "R10 single pass removes one line of set 5", hit_cnt, 1);
        lf = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_fill({lf[12:0], 7'b0}, lf[3]);
        end
        run_flush(20'h0, 4 * 16'h180, 1, 20'h80, 0);
        run_flush(20'h0, 16'h180, 1, 20'h80, 0);
        chk(hit_cnt == 0, "R10 nothing left after four passes", hit_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule